// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-port synchronous memory that accepts one command on every enabled clock edge: a read, a write or a deselect. The write data for a write arrives two enabled edges after its address, which matches the read latency. Reads and writes can therefore alternate on consecutive cycles and the data bus never loses a cycle to turnaround. The array is split into byte lanes with separate active-low write enables. By default it holds 1024 words of 18 bits in two 9-bit lanes.

A command is loaded with `new_cmd_n` low. With `new_cmd_n` high the block continues the active burst. It steps the two low address bits of the loaded base address and keeps the upper bits, and the command type stays the same. A write that is followed one cycle later by a read of the same address gets its captured data forwarded into that read, lane by lane. When `clk_en` is low the whole pipeline holds its state. `out_en` gates only the visible outputs.

Top module: `turnfree_sram`

## Requirements
- R1: A command is loaded only on an enabled edge with `new_cmd_n` low. There, `sel` low loads a deselect, and `sel` high loads a read (`wr`=0) or a write (`wr`=1). A deselect produces no read data and writes nothing.
- R2: A write loaded on edge N takes its address and `lane_we_n` on edge N, and takes its data from `wdata` on edge N+2. Bit i of `lane_we_n` low enables lane i, which is `wdata[9i+8:9i]`. Lanes that are not enabled keep their contents.
- R3: For a read loaded on edge N, `rvalid` is high and `rdata` holds the word after edge N+2. In the output slots of writes and deselects, `rvalid` is low.
- R4: With `new_cmd_n` high during an active burst, access k after the loaded base (k = 0, 1, 2, …) uses the base address with its low two bits replaced by (base[1:0] + k) mod 4. The fifth access returns to the base address.
- R5: A burst continuation keeps the loaded read/write type and ignores `sel`, `wr` and `addr`. Each continued write takes `lane_we_n` on its own edge.
- R6: While `clk_en` is low, all inputs are ignored. No command, write data or output changes, and pending operations finish on later enabled edges.
- R7: `new_cmd_n` high when no burst is active (after reset or after a deselect) acts as a deselect.
- R8: A read loaded one edge after a write to the same address returns the new data in the enabled lanes and the earlier array contents in the other lanes.
- R9: With `out_en` low, `rdata` is zero and `rvalid` is low. Raising `out_en` again shows the held result without a clock edge.
- R10: After synchronous reset, `rvalid` is low, `rdata` is zero and no command is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | High: edge is enabled; low: all state holds |
| addr | input | ADDR_W | Word address for a loaded command |
| new_cmd_n | input | 1 | Low: load a new command; high: continue burst |
| sel | input | 1 | High: chip selected on load; low: deselect |
| wr | input | 1 | Command type on load: 1 write, 0 read |
| lane_we_n | input | LANES | Active-low per-lane write enables |
| out_en | input | 1 | Output enable for rdata and rvalid |
| wdata | input | LANES*LANE_W | Write data, due two enabled edges after its address |
| rdata | output | LANES*LANE_W | Registered read data, zero when out_en is low |
| rvalid | output | 1 | High in the output slot of a read |

## Verification
Read results are due after the second enabled edge that follows the load. Write data is driven in the cycle of the second enabled edge after its address. The bench drives every input just after a falling edge and samples one nanosecond after each rising edge. Each table row therefore holds the inputs for one edge and the output expected after that same edge, and the row two places after a command carries that command's result or data. In the freeze test the expected edge numbers are counted on enabled edges only, and the visible outputs are checked at every disabled edge. The output-enable check is made between edges, so no register can be involved.

// File: rtl/tf_pkg.sv
package tf_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;

  // linear position inside a four-word burst
  function automatic logic [1:0] burst_pos(input logic [1:0] base_lo,
                                           input logic [1:0] step);
    return base_lo + step;
  endfunction

endpackage

// File: rtl/tf_cmd_seq.sv
module tf_cmd_seq
  import tf_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              new_cmd_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_we_n,
  output cmd_e              s1_kind,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [LANES-1:0]  s1_we
);

  cmd_e              kind_q;
  logic              burst_on_q;
  logic [1:0]        step_q;
  logic [ADDR_W-1:0] base_q;
  logic [LANES-1:0]  we_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q     <= CMD_IDLE;
      burst_on_q <= 1'b0;
      step_q     <= 2'd0;
      base_q     <= '0;
      we_q       <= '0;
    end else if (ce) begin
      if (!new_cmd_n) begin
        if (sel) begin
          kind_q     <= wr ? CMD_WRITE : CMD_READ;
          burst_on_q <= 1'b1;
          base_q     <= addr;
          step_q     <= 2'd0;
          we_q       <= ~lane_we_n;
        end else begin
          kind_q     <= CMD_IDLE;
          burst_on_q <= 1'b0;
          we_q       <= '0;
        end
      end else if (burst_on_q) begin
        step_q <= step_q + 2'd1;
        we_q   <= ~lane_we_n;
      end else begin
        kind_q <= CMD_IDLE;
        we_q   <= '0;
      end
    end
  end

  assign s1_kind = kind_q;
  assign s1_addr = {base_q[ADDR_W-1:2], burst_pos(base_q[1:0], step_q)};
  assign s1_we   = we_q;

  // R4: continuation steps the burst position and keeps the base
  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (ce && new_cmd_n && burst_on_q) |=>
      (s1_addr[1:0] == 2'($past(s1_addr[1:0]) + 2'd1)) &&
      (s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2])));

  // R5: continuation keeps the command type
  p_keep_type_r5: assert property (@(posedge clk) disable iff (rst)
    (ce && new_cmd_n && burst_on_q) |=> (s1_kind == $past(s1_kind)));

  // R7: continuation without a burst is a deselect
  p_orphan_r7: assert property (@(posedge clk) disable iff (rst)
    (ce && new_cmd_n && !burst_on_q) |=> (s1_kind == CMD_IDLE));

  // R6: command stage holds while disabled
  p_hold_cmd_r6: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(s1_kind) && $stable(s1_addr) && $stable(s1_we)));

endmodule

// File: rtl/tf_lane_mem.sv
module tf_lane_mem #(
  parameter int ADDR_W = 10,
  parameter int WIDTH  = 9
) (
  input  logic              clk,
  input  logic              ce,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (ce) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/tf_read_merge.sv
module tf_read_merge #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ce,
  input  logic                     s1_is_read,
  input  logic [ADDR_W-1:0]        s1_addr,
  input  logic                     s2_is_write,
  input  logic [ADDR_W-1:0]        s2_addr,
  input  logic [LANES-1:0]         s2_we,
  input  logic [LANES*LANE_W-1:0]  wdata,
  input  logic [LANES*LANE_W-1:0]  ram_q,
  output logic [LANES*LANE_W-1:0]  rd_q,
  output logic                     rd_v
);

  localparam int DATA_W = LANES * LANE_W;

  logic [LANES-1:0]  fwd_mask_q;
  logic [DATA_W-1:0] fwd_data_q;
  logic              rd_pend_q;
  logic [DATA_W-1:0] merged;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign merged[i*LANE_W +: LANE_W] = fwd_mask_q[i] ?
      fwd_data_q[i*LANE_W +: LANE_W] : ram_q[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_mask_q <= '0;
      fwd_data_q <= '0;
      rd_pend_q  <= 1'b0;
      rd_v       <= 1'b0;
      rd_q       <= '0;
    end else if (ce) begin
      fwd_mask_q <= (s1_is_read && s2_is_write && (s1_addr == s2_addr)) ?
                    s2_we : '0;
      fwd_data_q <= wdata;
      rd_pend_q  <= s1_is_read;
      rd_v       <= rd_pend_q;
      if (rd_pend_q) rd_q <= merged;
    end
  end

  // R6: output register frozen while disabled
  p_freeze_out_r6: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(rd_q) && $stable(rd_v)));

endmodule

// File: rtl/turnfree_sram.sv
module turnfree_sram
  import tf_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clk_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     new_cmd_n,
  input  logic                     sel,
  input  logic                     wr,
  input  logic [LANES-1:0]         lane_we_n,
  input  logic                     out_en,
  input  logic [LANES*LANE_W-1:0]  wdata,
  output logic [LANES*LANE_W-1:0]  rdata,
  output logic                     rvalid
);

  localparam int DATA_W = LANES * LANE_W;

  cmd_e              s1_kind;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_we;

  cmd_e              s2_kind;
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_we;

  logic [DATA_W-1:0] ram_q;
  logic [DATA_W-1:0] rd_q;
  logic              rd_v;
  logic              s1_is_read;
  logic              s2_is_write;

  tf_cmd_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .ce        (clk_en),
    .new_cmd_n (new_cmd_n),
    .sel       (sel),
    .wr        (wr),
    .addr      (addr),
    .lane_we_n (lane_we_n),
    .s1_kind   (s1_kind),
    .s1_addr   (s1_addr),
    .s1_we     (s1_we)
  );

  // second slot: the write waits here for its data
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_kind <= CMD_IDLE;
      s2_addr <= '0;
      s2_we   <= '0;
    end else if (clk_en) begin
      s2_kind <= s1_kind;
      s2_addr <= s1_addr;
      s2_we   <= s1_we;
    end
  end

  assign s1_is_read  = (s1_kind == CMD_READ);
  assign s2_is_write = (s2_kind == CMD_WRITE);

  for (genvar i = 0; i < LANES; i++) begin : g_mem
    tf_lane_mem #(.ADDR_W(ADDR_W), .WIDTH(LANE_W)) u_mem (
      .clk   (clk),
      .ce    (clk_en),
      .we    (s2_is_write && s2_we[i]),
      .waddr (s2_addr),
      .wdata (wdata[i*LANE_W +: LANE_W]),
      .re    (s1_is_read),
      .raddr (s1_addr),
      .rdata (ram_q[i*LANE_W +: LANE_W])
    );
  end

  tf_read_merge #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_merge (
    .clk         (clk),
    .rst         (rst),
    .ce          (clk_en),
    .s1_is_read  (s1_is_read),
    .s1_addr     (s1_addr),
    .s2_is_write (s2_is_write),
    .s2_addr     (s2_addr),
    .s2_we       (s2_we),
    .wdata       (wdata),
    .ram_q       (ram_q),
    .rd_q        (rd_q),
    .rd_v        (rd_v)
  );

  assign rdata  = out_en ? rd_q : '0;
  assign rvalid = out_en & rd_v;

  // R3: a read in the data slot yields a valid result on the next enabled edge
  p_rd_lat_r3: assert property (@(posedge clk) disable iff (rst)
    (clk_en && s2_kind == CMD_READ) |=> rd_v);

  // R3: writes and deselects leave no result in their slot
  p_no_ghost_r3: assert property (@(posedge clk) disable iff (rst)
    (clk_en && s2_kind != CMD_READ) |=> !rd_v);

  // R6: data slot frozen while disabled
  p_hold_slot_r6: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(s2_kind) && $stable(s2_addr) && $stable(s2_we)));

endmodule

// File: tb/tb_turnfree_sram.sv
`timescale 1ns/1ps
module tb_turnfree_sram;

  localparam int AW = 10;
  localparam int DW = 18;
  localparam int NV = 21;
  localparam int VW = 1 + 1 + 1 + 2 + AW + DW + 1 + DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clk_en = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          new_cmd_n = 1'b0;
  logic          sel = 1'b0;
  logic          wr = 1'b0;
  logic [1:0]    lane_we_n = 2'b11;
  logic          out_en = 1'b1;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rvalid;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  turnfree_sram dut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .addr(addr),
    .new_cmd_n(new_cmd_n), .sel(sel), .wr(wr), .lane_we_n(lane_we_n),
    .out_en(out_en), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  // fields: new_cmd_n, sel, wr, lane_we_n, addr, wdata, exp_valid, exp_data
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0,1'b1,1'b1,2'b00,10'h010,18'h00000,1'b0,18'h00000}, // 0 write 010
    {1'b0,1'b1,1'b1,2'b00,10'h011,18'h00000,1'b0,18'h00000}, // 1 write 011
    {1'b0,1'b1,1'b0,2'b11,10'h010,18'h12345,1'b0,18'h00000}, // 2 read 010, data of 0
    {1'b0,1'b1,1'b0,2'b11,10'h011,18'h0ABCD,1'b0,18'h00000}, // 3 read 011, data of 1
    {1'b0,1'b0,1'b0,2'b11,10'h000,18'h00000,1'b1,18'h12345}, // 4 deselect
    {1'b0,1'b1,1'b1,2'b10,10'h010,18'h00000,1'b1,18'h0ABCD}, // 5 write lane0 only
    {1'b0,1'b1,1'b0,2'b11,10'h010,18'h00000,1'b0,18'h00000}, // 6 read right after
    {1'b0,1'b0,1'b0,2'b11,10'h000,18'h3FFFF,1'b0,18'h00000}, // 7 deselect, data of 5
    {1'b1,1'b0,1'b0,2'b11,10'h000,18'h00000,1'b1,18'h123FF}, // 8 orphan continue
    {1'b0,1'b1,1'b1,2'b00,10'h022,18'h00000,1'b0,18'h00000}, // 9 burst write base 022
    {1'b1,1'b0,1'b0,2'b00,10'h000,18'h00000,1'b0,18'h00000}, // 10 continue -> 023
    {1'b1,1'b0,1'b0,2'b00,10'h000,18'h00001,1'b0,18'h00000}, // 11 continue -> 020
    {1'b1,1'b0,1'b0,2'b00,10'h000,18'h00002,1'b0,18'h00000}, // 12 continue -> 021
    {1'b1,1'b0,1'b0,2'b00,10'h000,18'h00003,1'b0,18'h00000}, // 13 wraps -> 022
    {1'b0,1'b1,1'b0,2'b11,10'h021,18'h00004,1'b0,18'h00000}, // 14 burst read base 021
    {1'b1,1'b0,1'b1,2'b11,10'h000,18'h00005,1'b0,18'h00000}, // 15 continue -> 022
    {1'b1,1'b0,1'b1,2'b11,10'h000,18'h00000,1'b1,18'h00004}, // 16 continue -> 023
    {1'b1,1'b0,1'b1,2'b11,10'h000,18'h00000,1'b1,18'h00005}, // 17 continue -> 020
    {1'b0,1'b0,1'b0,2'b11,10'h000,18'h00000,1'b1,18'h00002}, // 18 deselect
    {1'b0,1'b0,1'b0,2'b11,10'h000,18'h00000,1'b1,18'h00003}, // 19 deselect
    {1'b0,1'b0,1'b0,2'b11,10'h000,18'h00000,1'b0,18'h00000}  // 20 deselect
  };

  function automatic string tag_of(input int k);
    if (k <= 5)  return "R2";
    if (k == 6)  return "R1";
    if (k <= 8)  return "R8";
    if (k <= 10) return "R7";
    if (k <= 16) return "R4";
    return "R5";
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic ce, input logic nc, input logic s,
                      input logic w, input logic [1:0] be,
                      input logic [AW-1:0] a, input logic [DW-1:0] wd);
    @(negedge clk);
    clk_en = ce; new_cmd_n = nc; sel = s; wr = w;
    lane_we_n = be; addr = a; wdata = wd;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input logic [DW-1:0] wd);
    step(1'b1, 1'b0, 1'b0, 1'b0, 2'b11, '0, wd);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) idle('0);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    check("R10", "rvalid after reset", DW'(rvalid), DW'(0));
    check("R10", "rdata after reset", rdata, '0);

    // table walk
    for (int k = 0; k < NV; k++) begin
      logic [VW-1:0] v;
      v = VEC[k];
      step(1'b1, v[VW-1], v[VW-2], v[VW-3], v[VW-4 -: 2],
           v[VW-6 -: AW], v[DW + DW : DW + 1]);
      check(v[DW] ? "R3" : tag_of(k), "rvalid", DW'(rvalid), DW'(v[DW]));
      if (v[DW]) check(tag_of(k), "rdata", rdata, v[DW-1:0]);
    end

    // R6: freeze with a pending write and a pending read
    idle('0);
    step(1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 10'h030, '0);     // write 030
    step(1'b1, 1'b0, 1'b1, 1'b0, 2'b11, 10'h010, '0);     // read 010
    for (int j = 0; j < 3; j++) begin
      step(1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 10'h030, 18'h2AAAA);
      check("R6", "rvalid while frozen", DW'(rvalid), DW'(0));
    end
    idle(18'h15555);                                       // data for write 030
    check("R6", "rvalid first enabled edge", DW'(rvalid), DW'(0));
    idle('0);
    check("R6", "rvalid read across freeze", DW'(rvalid), DW'(1));
    check("R6", "rdata read across freeze", rdata, 18'h123FF);
    step(1'b1, 1'b0, 1'b1, 1'b0, 2'b11, 10'h030, '0);     // read 030
    idle('0);
    idle('0);
    check("R6", "rvalid write after freeze", DW'(rvalid), DW'(1));
    check("R6", "rdata write after freeze", rdata, 18'h15555);

    // R9: output enable gates the visible outputs only
    out_en = 1'b0;
    #0.3;
    check("R9", "rdata with out_en low", rdata, '0);
    check("R9", "rvalid with out_en low", DW'(rvalid), DW'(0));
    out_en = 1'b1;
    #0.3;
    check("R9", "rdata restored", rdata, 18'h15555);

    // R2: upper lane only
    step(1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 10'h040, '0);
    step(1'b1, 1'b0, 1'b1, 1'b1, 2'b01, 10'h040, '0);
    idle(18'h3FFFF);
    idle(18'h00000);
    step(1'b1, 1'b0, 1'b1, 1'b0, 2'b11, 10'h040, '0);
    idle('0);
    idle('0);
    check("R2", "rvalid lane1 write", DW'(rvalid), DW'(1));
    check("R2", "rdata lane1 write", rdata, 18'h001FF);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule